// File: doc/BRIEF.md
# Shadow RAM Routing Controller

This block holds the configuration that decides, for the upper-memory window from C0000h to FFFFFh, whether processor memory cycles are served by on-board DRAM or passed to the external expansion bus. Software reaches the configuration through two byte-wide I/O ports. One port takes a register number. The other port reads or writes the register that number selects.

The window has two parts. The lower half (C0000h–DFFFFh) is split into eight 16 KB segments. The upper half is split into two 64 KB segments (E0000h–EFFFFh and F0000h–FFFFFh). Each segment has a read-enable bit and a write-enable bit. A combinational lookup takes a 20-bit memory address and a read/write flag and returns one of three routing codes: DRAM, external bus, or drop.

Setting the read-enable bit while leaving the write-enable bit clear write-protects a shadow copy of a ROM. In that state reads come from DRAM and writes are discarded. Configuration register 02h also drives an external cache-enable output.

Top module: `shadow_map_ctrl`

## Requirements
- R1: After reset, the index and all 16 configuration registers are 00h. Every register therefore reads back as 00h, every window segment routes reads and writes to the external bus, and `cache_en` is 0.
- R2: A write to I/O address 22h loads the index. Any read at an address other than 24h returns FFh, and this includes 22h.
- R3: A read at 24h returns the register the index selects, and a write at 24h stores into that register. When the index is 10h or above, a read at 24h returns FFh and a write at 24h changes no register.
- R4: Small segment k (k = 0..7, base C0000h + k·4000h) uses a register and two bits as follows:
  - Register 04h serves k = 0..3 and register 05h serves k = 4..7.
  - The read-enable is bit 2·(k mod 4).
  - The write-enable is bit 2·(k mod 4)+1.
- R5: In register 06h, bits 0 and 1 are the read-enable and write-enable for E0000h–EFFFFh. Bits 2 and 3 are the read-enable and write-enable for F0000h–FFFFFh.
- R6: For a read (`mem_we`=0), `route` is 00 (DRAM) when the segment's read-enable is set and 01 (external bus) when it is clear. A read never yields 10.
- R7: For a write (`mem_we`=1), `route` depends on the segment's bits:
  - 00 (DRAM) when the write-enable is set.
  - 10 (drop) when the write-enable is clear and the read-enable is set.
  - 01 (external bus) when both bits are clear.
  - The code 11 never appears.
- R8: Any address below C0000h routes to 00 (DRAM) for both reads and writes, whatever the register contents.
- R9: `cache_en` is 1 exactly when bits 2 and 3 of register 02h are both set.
- R10: A data-port write changes `route` and `cache_en` starting in the clock cycle after the edge that stores it. Before that edge, the outputs keep their old values.
- R11: Writes to I/O addresses other than 22h and 24h change neither the index nor any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| mem_addr | input | 20 | Memory address to classify |
| mem_we | input | 1 | 1 = write cycle, 0 = read cycle |
| route | output | 2 | 00 DRAM, 01 external bus, 10 drop |
| cache_en | output | 1 | External cache enable |

## Verification
The bench builds the block with its default parameters: an 8-bit index and data path, 16 registers, ports 22h and 24h, a 20-bit address, 16 KB small segments and 64 KB large segments.

Because the index is a full byte, an out-of-range index such as 20h can be reached through the normal port protocol. This lets the bench confirm both the FFh readback and the ignored write.

With these sizes, all ten segment boundaries fall at fixed addresses. The bench can therefore visit the first and last byte of each segment under all four bit combinations. While it does so, it sets neighbouring segments to the opposite combination, so that a misplaced bit shows up as a wrong route.

// File: rtl/shadow_map_pkg.sv
// Shared definitions for the shadow RAM routing controller.
// Assumes an 8-bit register map with fixed register numbers.
package shadow_map_pkg;

    // Routing decision for one memory cycle
    typedef enum logic [1:0] {
        RT_DRAM = 2'b00,
        RT_EXT  = 2'b01,
        RT_DROP = 2'b10
    } route_e;

    // Register numbers whose bits the decoder consumes
    localparam int REG_CACHE  = 2;
    localparam int REG_SEG_LO = 4;
    localparam int REG_SEG_MD = 5;
    localparam int REG_SEG_HI = 6;

endpackage

// File: rtl/shadow_io_regs.sv
// Index/data register pair on a narrow I/O bus.
// What it does: a write to IDX_PORT loads the index, and the data port reads
// or writes the register the index selects.
// Assumptions:
// - An index at or above NUM_REGS reads FFh and ignores writes.
// - Reads are combinational.
// - Reset is synchronous and active low.
module shadow_io_regs #(
    parameter int                IO_AW     = 8,
    parameter int                DW        = 8,
    parameter int                NUM_REGS  = 16,
    parameter logic [IO_AW-1:0]  IDX_PORT  = 'h22,
    parameter logic [IO_AW-1:0]  DATA_PORT = 'h24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IO_AW-1:0]              io_addr,
    input  logic                          io_wr,
    input  logic                          io_rd,
    input  logic [DW-1:0]                 io_wdata,
    output logic [DW-1:0]                 io_rdata,
    output logic [NUM_REGS-1:0][DW-1:0]   regs_o
);
    localparam int          IW     = $clog2(NUM_REGS);
    localparam logic [DW:0] NREG_W = (DW+1)'(NUM_REGS);

    logic [DW-1:0] index_q;
    logic          idx_hit;
    logic          dat_hit;
    logic          idx_ok;
    logic [IW-1:0] sel;

    assign idx_hit = (io_addr == IDX_PORT);
    assign dat_hit = (io_addr == DATA_PORT);
    assign idx_ok  = ({1'b0, index_q} < NREG_W);
    assign sel     = index_q[IW-1:0];

    // Index register: loaded by a write to the index port
    always_ff @(posedge clk) begin
        if (!rst_n)              index_q <= '0;
        else if (io_wr && idx_hit) index_q <= io_wdata;
    end

    // One storage register per configuration slot
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_o[g] <= '0;
            else if (io_wr && dat_hit && idx_ok && (sel == IW'(g)))
                regs_o[g] <= io_wdata;
        end
    end

    // Read mux: selected register on a valid data-port read, FFh otherwise
    always_comb begin
        io_rdata = '1;
        if (io_rd && dat_hit && idx_ok) io_rdata = regs_o[sel];
    end

endmodule

// File: rtl/shadow_seg_decode.sv
// Segment decoder for the upper-memory window.
// What it does: finds the segment that holds mem_addr and returns that
// segment's read-enable and write-enable bits.
// Assumptions:
// - The window is the top quarter of the address space. Its lower half holds
//   N_SMALL small segments and its upper half holds N_LARGE large segments.
// - An address outside the window reports both enables set, which means DRAM.
module shadow_seg_decode #(
    parameter int DW         = 8,
    parameter int MEM_AW     = 20,
    parameter int N_SMALL    = 8,
    parameter int N_LARGE    = 2,
    parameter int SMALL_LOG2 = 14,
    parameter int LARGE_LOG2 = 16
) (
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic [DW-1:0]     reg_lo,
    input  logic [DW-1:0]     reg_md,
    input  logic [DW-1:0]     reg_hi,
    output logic              in_window,
    output logic              rd_en,
    output logic              wr_en
);
    localparam int SIW = $clog2(N_SMALL);
    localparam int LIW = (N_LARGE > 1) ? $clog2(N_LARGE) : 1;

    logic [2*DW-1:0]    small_bits;
    logic [N_SMALL-1:0] small_rd;
    logic [N_SMALL-1:0] small_wr;
    logic [N_LARGE-1:0] large_rd;
    logic [N_LARGE-1:0] large_wr;
    logic [SIW-1:0]     s_idx;
    logic [LIW-1:0]     l_idx;
    logic               upper_half;
    logic               unused_bits;

    assign small_bits = {reg_md, reg_lo};

    // Split the two small-segment registers into per-segment enables
    for (genvar s = 0; s < N_SMALL; s++) begin : g_small
        assign small_rd[s] = small_bits[2*s];
        assign small_wr[s] = small_bits[2*s+1];
    end

    // Split the large-segment register into per-segment enables
    for (genvar l = 0; l < N_LARGE; l++) begin : g_large
        assign large_rd[l] = reg_hi[2*l];
        assign large_wr[l] = reg_hi[2*l+1];
    end

    assign in_window  = &mem_addr[MEM_AW-1 -: 2];
    assign upper_half = mem_addr[MEM_AW-3];
    assign s_idx      = mem_addr[SMALL_LOG2 +: SIW];
    assign l_idx      = mem_addr[LARGE_LOG2 +: LIW];
    assign unused_bits = ^{mem_addr[SMALL_LOG2-1:0], reg_hi[DW-1:2*N_LARGE]};

    // Pick the enable pair for the segment that holds the address
    always_comb begin
        if (!in_window) begin
            rd_en = 1'b1;
            wr_en = 1'b1;
        end else if (upper_half) begin
            rd_en = large_rd[l_idx];
            wr_en = large_wr[l_idx];
        end else begin
            rd_en = small_rd[s_idx];
            wr_en = small_wr[s_idx];
        end
    end

endmodule

// File: rtl/shadow_route_sel.sv
// Turns a segment's enable pair and the cycle direction into a route code.
// What it does:
// - A read goes to DRAM when read-enabled, and to the bus otherwise.
// - A write goes to DRAM when write-enabled. A write to a read-only shadow
//   segment is dropped. Any other write goes to the bus.
// Assumption: purely combinational, so it adds no cycle of latency.
module shadow_route_sel
    import shadow_map_pkg::*;
(
    input  logic   rd_en,
    input  logic   wr_en,
    input  logic   mem_we,
    output route_e route
);
    // Three-way routing choice
    always_comb begin
        if (!mem_we)     route = rd_en ? RT_DRAM : RT_EXT;
        else if (wr_en)  route = RT_DRAM;
        else if (rd_en)  route = RT_DROP;
        else             route = RT_EXT;
    end

endmodule

// File: rtl/shadow_map_ctrl.sv
// Top level of the shadow RAM routing controller.
// What it does: joins the indexed register pair, the segment decoder and the
// route selector, and derives the external cache enable.
// Assumption: the outputs follow the stored register contents, so a new
// setting shows from the cycle after the write edge.
module shadow_map_ctrl
    import shadow_map_pkg::*;
#(
    parameter int                IO_AW      = 8,
    parameter int                DW         = 8,
    parameter int                NUM_REGS   = 16,
    parameter int                MEM_AW     = 20,
    parameter int                N_SMALL    = 8,
    parameter int                N_LARGE    = 2,
    parameter int                SMALL_LOG2 = 14,
    parameter int                LARGE_LOG2 = 16,
    parameter logic [IO_AW-1:0]  IDX_PORT   = 'h22,
    parameter logic [IO_AW-1:0]  DATA_PORT  = 'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DW-1:0]     io_wdata,
    output logic [DW-1:0]     io_rdata,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_we,
    output logic [1:0]        route,
    output logic              cache_en
);
    logic [NUM_REGS-1:0][DW-1:0] regs;
    logic   in_window;
    logic   rd_en;
    logic   wr_en;
    route_e route_sel;
    logic   unused_reg_bits;
    logic   unused_win;

    shadow_io_regs #(
        .IO_AW(IO_AW), .DW(DW), .NUM_REGS(NUM_REGS),
        .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .regs_o(regs)
    );

    shadow_seg_decode #(
        .DW(DW), .MEM_AW(MEM_AW), .N_SMALL(N_SMALL), .N_LARGE(N_LARGE),
        .SMALL_LOG2(SMALL_LOG2), .LARGE_LOG2(LARGE_LOG2)
    ) u_dec (
        .mem_addr(mem_addr), .reg_lo(regs[REG_SEG_LO]),
        .reg_md(regs[REG_SEG_MD]), .reg_hi(regs[REG_SEG_HI]),
        .in_window(in_window), .rd_en(rd_en), .wr_en(wr_en)
    );

    shadow_route_sel u_sel (
        .rd_en(rd_en), .wr_en(wr_en), .mem_we(mem_we), .route(route_sel)
    );

    // Route code out of the selector, cache enable from both control bits
    assign route           = route_sel;
    assign cache_en        = regs[REG_CACHE][2] & regs[REG_CACHE][3];
    assign unused_reg_bits = ^regs;
    assign unused_win      = in_window;

endmodule

// File: rtl/shadow_map_chk.sv
// Assertion checker for shadow_map_ctrl. It observes ports only and is
// attached with the bind at the end of this file.
module shadow_map_chk #(
    parameter int               IO_AW     = 8,
    parameter int               DW        = 8,
    parameter int               MEM_AW    = 20,
    parameter logic [IO_AW-1:0] DATA_PORT = 'h24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IO_AW-1:0]  io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [DW-1:0]     io_rdata,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mem_we,
    input logic [1:0]        route,
    input logic              cache_en
);
    AST_RESET_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && io_rd && io_addr == DATA_PORT) |-> io_rdata == '0); // R1

    AST_NON_DATA_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_addr == DATA_PORT) |-> io_rdata == '1); // R2

    AST_READ_NEVER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> route != 2'b10); // R6

    AST_ROUTE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        route != 2'b11); // R7

    AST_LOW_MEM_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr[MEM_AW-1 -: 2] != 2'b11) |-> route == 2'b00); // R8

    AST_CACHE_RISE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(cache_en)) |-> $past(io_wr)); // R9

    AST_ROUTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(io_wr) && $stable(mem_addr) && $stable(mem_we))
        |-> $stable(route)); // R10

endmodule

bind shadow_map_ctrl shadow_map_chk #(
    .IO_AW(IO_AW), .DW(DW), .MEM_AW(MEM_AW), .DATA_PORT(DATA_PORT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .route(route), .cache_en(cache_en)
);

// File: tb/shadow_map_ctrl_tb.sv
// Directed bench for shadow_map_ctrl. Each scenario runs as its own task.
module shadow_map_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [19:0] mem_addr = '0;
    logic        mem_we = 1'b0;
    logic [1:0]  route;
    logic        cache_en;

    int n_checks = 0;
    int n_err = 0;
    logic [7:0] mreg [16];
    bit done = 0;

    shadow_map_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .route(route),
        .cache_en(cache_en)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] v);
        io_write(8'h22, idx);
        io_write(8'h24, v);
        if (idx < 16) mreg[idx] = v;
    endtask

    // Expected route, from R4..R8
    function automatic logic [1:0] exp_route(input logic [19:0] a, input logic w);
        logic rd, wr;
        logic [7:0] r;
        int k;
        if (a < 20'hC0000) return 2'b00;
        if (a < 20'hE0000) begin
            k = int'((a - 20'hC0000) >> 14);
            r = mreg[4 + k / 4];
            rd = r[2 * (k % 4)];
            wr = r[2 * (k % 4) + 1];
        end else begin
            k = int'((a - 20'hE0000) >> 16);
            r = mreg[6];
            rd = r[2 * k];
            wr = r[2 * k + 1];
        end
        if (!w) return rd ? 2'b00 : 2'b01;
        if (wr) return 2'b00;
        return rd ? 2'b10 : 2'b01;
    endfunction

    task automatic chk_route(input string tag, input logic [19:0] a);
        for (int w = 0; w < 2; w++) begin
            @(negedge clk);
            mem_addr = a; mem_we = w[0];
            #1 chk(tag, {30'd0, route}, {30'd0, exp_route(a, w[0])});
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int i = 0; i < 16; i++) begin
            io_write(8'h22, 8'(i));
            io_read(8'h24, d);
            chk("R1 reg after reset", d, 0);
        end
        chk_route("R1 window external after reset", 20'hC0000);
        chk_route("R1 window external after reset", 20'hFFFFF);
        chk("R1 cache_en after reset", cache_en, 0);
    endtask

    task automatic t_ports;
        logic [7:0] d;
        set_reg(8'h03, 8'h5C);
        io_read(8'h22, d);
        chk("R2 index port read FF", d, 8'hFF);
        io_read(8'h23, d);
        chk("R2 other port read FF", d, 8'hFF);
        io_write(8'h23, 8'h07);
        io_write(8'h25, 8'hEE);
        io_write(8'h20, 8'h11);
        io_read(8'h24, d);
        chk("R11 foreign writes ignored", d, 8'h5C);
    endtask

    task automatic t_regfile;
        logic [7:0] d;
        for (int i = 0; i < 16; i++) set_reg(8'(i), 8'(8'h31 * i + 8'h0B));
        for (int i = 0; i < 16; i++) begin
            io_write(8'h22, 8'(i));
            io_read(8'h24, d);
            chk("R3 register readback", d, mreg[i]);
        end
        io_write(8'h22, 8'h20);
        io_write(8'h24, 8'h5A);
        io_read(8'h24, d);
        chk("R3 out-of-range read FF", d, 8'hFF);
        for (int i = 0; i < 16; i++) begin
            io_write(8'h22, 8'(i));
            io_read(8'h24, d);
            chk("R3 out-of-range write ignored", d, mreg[i]);
        end
    endtask

    task automatic t_small;
        logic [7:0] lo, md;
        logic [19:0] base;
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 4; c++) begin
                lo = '0; md = '0;
                for (int k = 0; k < 8; k++) begin
                    if (k < 4) lo[2*k +: 2] = (k == s) ? 2'(c) : 2'(3 - c);
                    else       md[2*(k-4) +: 2] = (k == s) ? 2'(c) : 2'(3 - c);
                end
                set_reg(8'h04, lo);
                set_reg(8'h05, md);
                base = 20'hC0000 + 20'(s) * 20'h4000;
                chk_route("R4 R6 R7 small first byte", base);
                chk_route("R4 R6 R7 small last byte", base + 20'h3FFF);
            end
        end
    endtask

    task automatic t_large;
        logic [7:0] hi;
        logic [19:0] base;
        for (int l = 0; l < 2; l++) begin
            for (int c = 0; c < 4; c++) begin
                hi = '0;
                hi[2*l +: 2] = 2'(c);
                hi[2*(1-l) +: 2] = 2'(3 - c);
                set_reg(8'h06, hi);
                base = 20'hE0000 + 20'(l) * 20'h10000;
                chk_route("R5 R6 R7 large first byte", base);
                chk_route("R5 R6 R7 large last byte", base + 20'hFFFF);
            end
        end
    endtask

    task automatic t_low;
        set_reg(8'h04, 8'h00);
        set_reg(8'h05, 8'h00);
        set_reg(8'h06, 8'h00);
        chk_route("R8 low memory DRAM", 20'h00000);
        chk_route("R8 low memory DRAM", 20'h9FFFF);
        chk_route("R8 low memory DRAM", 20'hBFFFF);
    endtask

    task automatic t_cache;
        logic [7:0] vals [4] = '{8'h04, 8'h08, 8'h0C, 8'hF3};
        logic       exps [4] = '{1'b0, 1'b0, 1'b1, 1'b0};
        for (int i = 0; i < 4; i++) begin
            set_reg(8'h02, vals[i]);
            #1 chk("R9 cache_en", cache_en, exps[i]);
        end
    endtask

    task automatic t_timing;
        set_reg(8'h04, 8'h00);
        io_write(8'h22, 8'h04);
        @(negedge clk);
        mem_addr = 20'hC0000; mem_we = 1'b0;
        io_addr = 8'h24; io_wdata = 8'h01; io_wr = 1'b1;
        #1 chk("R10 route before write edge", route, 2'b01);
        @(posedge clk);
        #1 chk("R10 route after write edge", route, 2'b00);
        @(negedge clk);
        io_wr = 1'b0;
        mreg[4] = 8'h01;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mreg[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ports();
        t_regfile();
        t_small();
        t_large();
        t_low();
        t_cache();
        t_timing();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule